// File: doc/BRIEF.md
# Two's Complement Floating Point Adder/Subtractor

This block adds or subtracts two floating point operands. Each operand has a 24-bit two's complement mantissa and an 8-bit signed exponent. An operand's value is the mantissa, read as a signed integer, times two to the power of the exponent.

The operand with the larger exponent becomes the reference. The other operand's mantissa is arithmetically shifted right by the exponent difference into a wide intermediate. That intermediate holds the 24 mantissa bits, 8 fraction bits below them and two guard bits above them. The sum is formed exactly at that width. It is then renormalized to the 24-bit format by truncation toward negative infinity. Results too large for the exponent field saturate and raise an overflow flag. Results too small to be normalized are flushed to zero and raise an underflow flag.

Operations enter with a valid strobe, one per cycle if needed. Each result leaves exactly three clock cycles later with its own valid strobe.

Top module: `tcf_addsub`

## Requirements
- R1: `outValid` rises exactly three rising clock edges after the edge that captured `inValid`=1. One operation can be accepted on every cycle. `outValid` is 0 after reset and whenever no operation was accepted three cycles earlier.
- R2: A nonzero, non-flagged result is normalized, meaning bit 23 of `resMant` differs from bit 22. Its value `resMant`×2^`resExp` is the extended result truncated to 24 bits. Bit 23 is the mantissa sign.
- R3: When the normalized exponent would exceed +127, `ovfFlag` is 1 and `resExp` is 0x7F. `resMant` is then 0x7FFFFF for a positive result and 0x800000 for a negative one.
- R4: When the normalized exponent would fall below -128, the result is flushed to zero (`resMant`=0, `resExp`=0x80) and `unfFlag` is 1.
- R5: An exact zero sum gives `resMant`=0, `resExp`=0x80, with both flags clear.
- R6: When the exponent difference is 8 or less, no bit is lost in alignment. Operands within a factor of two of each other therefore subtract to the exact difference.
- R7: A shift of 32 or more leaves only sign fill from the smaller operand. A positive operand contributes 0 and a negative one contributes -1 unit of the lowest intermediate bit.
- R8: Subtraction negates the second mantissa inside the wide intermediate. Negating a mantissa of -2^23 therefore gives +2^23 without wrapping.
- R9: Reduction to 24 bits is a floor (arithmetic right shift) of the extended sum.
- R10: The operand with the larger exponent is the reference. On a tie, no shift is applied. Swapping the addends does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands present this cycle |
| subOp | input | 1 | 1 = a minus b, 0 = a plus b |
| aMant | input | 24 | Operand a mantissa, two's complement |
| aExp | input | 8 | Operand a exponent, two's complement |
| bMant | input | 24 | Operand b mantissa, two's complement |
| bExp | input | 8 | Operand b exponent, two's complement |
| outValid | output | 1 | Result present this cycle |
| resMant | output | 24 | Result mantissa |
| resExp | output | 8 | Result exponent |
| ovfFlag | output | 1 | Result exponent overflowed |
| unfFlag | output | 1 | Result flushed to zero |

## Verification
A fault in a stage register shows up in the result three cycles after the operation enters. There are three typical symptoms:
- a wrong exponent choice during alignment shows up as a value off by a power of two;
- a lost guard bit shows up as a wrapped sign when the most negative mantissa is subtracted;
- a broken leading-sign count shows up as a mantissa whose top two bits are equal.

The scoreboard compares every result against an independent wide-integer model. It also checks that each result arrives on exactly the third cycle, so any extra or missing stage register is caught on the first operation.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  // Stage load strobes issued by the control to the datapath.
  typedef struct packed {
    logic ld1;  // capture aligned operands
    logic ld2;  // capture exact sum
    logic ld3;  // capture normalized result
  } tcfStrobe_t;

endpackage

// File: rtl/tcf_ctrl.sv
module tcf_ctrl
  import tcf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output tcfStrobe_t strobes,
  output logic       outValid
);

  logic v1, v2, v3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_comb begin
    strobes.ld1 = inValid;
    strobes.ld2 = v1;
    strobes.ld3 = v2;
  end

  assign outValid = v3;

  // R1: every accepted operation leaves three edges later
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid);
  // R1: no result without an operation three edges earlier
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##3 !outValid);

endmodule

// File: rtl/tcf_norm.sv
module tcf_norm #(
  parameter int MW = 24,
  parameter int GW = 8,
  parameter int EW = 8
) (
  input  logic signed [MW+GW+1:0] sumIn,
  input  logic        [EW-1:0]    expIn,
  output logic        [MW-1:0]    mantOut,
  output logic        [EW-1:0]    expOut,
  output logic                    ovfOut,
  output logic                    unfOut
);

  localparam int SW   = MW + GW + 2;
  localparam int EMAX = 2**(EW-1) - 1;
  localparam int EMIN = -(2**(EW-1));

  int                   sigW;
  int                   kShift;
  int                   newExp;
  logic signed [SW-1:0] shifted;
  logic                 isZero;
  logic                 unusedHi;

  always_comb begin
    // number of significant bits including one sign bit
    sigW = 1;
    for (int i = 0; i < SW - 1; i++) begin
      if (sumIn[i] != sumIn[SW-1]) sigW = i + 2;
    end
    kShift = sigW - MW;
    newExp = int'($signed(expIn)) - GW + kShift;
    if (kShift >= 0) shifted = sumIn >>> kShift;
    else             shifted = sumIn <<< (-kShift);
    isZero = (sumIn == '0);

    ovfOut  = 1'b0;
    unfOut  = 1'b0;
    mantOut = shifted[MW-1:0];
    expOut  = EW'(newExp);
    if (isZero) begin
      mantOut = '0;
      expOut  = EW'(EMIN);
    end else if (newExp > EMAX) begin
      ovfOut  = 1'b1;
      expOut  = EW'(EMAX);
      mantOut = sumIn[SW-1] ? {1'b1, {(MW-1){1'b0}}} : {1'b0, {(MW-1){1'b1}}};
    end else if (newExp < EMIN) begin
      unfOut  = 1'b1;
      mantOut = '0;
      expOut  = EW'(EMIN);
    end
  end

  assign unusedHi = ^shifted[SW-1:MW];

endmodule

// File: rtl/tcf_dpath.sv
module tcf_dpath
  import tcf_pkg::*;
#(
  parameter int MW = 24,
  parameter int GW = 8,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  tcfStrobe_t    strobes,
  input  logic          outValid,
  input  logic          subOp,
  input  logic [MW-1:0] aMant,
  input  logic [EW-1:0] aExp,
  input  logic [MW-1:0] bMant,
  input  logic [EW-1:0] bExp,
  output logic [MW-1:0] resMant,
  output logic [EW-1:0] resExp,
  output logic          ovfFlag,
  output logic          unfFlag
);

  localparam int SW   = MW + GW + 2;
  localparam int EMAX = 2**(EW-1) - 1;
  localparam int EMIN = -(2**(EW-1));

  // ---------------- stage 1: negate, swap, align ----------------
  logic signed [SW-1:0] aExt, bExt, bEff, bigOp, smallOp, smallSh;
  logic signed [EW:0]   dA;
  logic        [EW:0]   diffMag;
  logic                 aGe;
  int                   shAmt;
  logic        [EW-1:0] bigExp;

  always_comb begin
    aExt    = {{2{aMant[MW-1]}}, aMant, {GW{1'b0}}};
    bExt    = {{2{bMant[MW-1]}}, bMant, {GW{1'b0}}};
    bEff    = subOp ? -bExt : bExt;
    dA      = $signed({aExp[EW-1], aExp}) - $signed({bExp[EW-1], bExp});
    aGe     = !dA[EW];
    diffMag = aGe ? unsigned'(dA) : unsigned'(-dA);
    bigOp   = aGe ? aExt : bEff;
    smallOp = aGe ? bEff : aExt;
    bigExp  = aGe ? aExp : bExp;
    shAmt   = (int'(diffMag) > SW - 1) ? SW - 1 : int'(diffMag);
    smallSh = smallOp >>> shAmt;
  end

  logic signed [SW-1:0] s1Big, s1Small;
  logic        [EW-1:0] s1Exp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Big   <= '0;
      s1Small <= '0;
      s1Exp   <= '0;
    end else if (strobes.ld1) begin
      s1Big   <= bigOp;
      s1Small <= smallSh;
      s1Exp   <= bigExp;
    end
  end

  // R10: the reference exponent is never below either input exponent
  p_bigexp_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ld1 |=> ($signed(s1Exp) >= $signed($past(aExp)) &&
                     $signed(s1Exp) >= $signed($past(bExp))));

  // ---------------- stage 2: exact sum ----------------
  logic signed [SW-1:0] s2Sum;
  logic        [EW-1:0] s2Exp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Sum <= '0;
      s2Exp <= '0;
    end else if (strobes.ld2) begin
      s2Sum <= s1Big + s1Small;
      s2Exp <= s1Exp;
    end
  end

  // ---------------- stage 3: normalize ----------------
  logic [MW-1:0] nMant;
  logic [EW-1:0] nExp;
  logic          nOvf, nUnf;

  tcf_norm #(.MW(MW), .GW(GW), .EW(EW)) u_norm (
    .sumIn  (s2Sum),
    .expIn  (s2Exp),
    .mantOut(nMant),
    .expOut (nExp),
    .ovfOut (nOvf),
    .unfOut (nUnf)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resMant <= '0;
      resExp  <= EW'(EMIN);
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else if (strobes.ld3) begin
      resMant <= nMant;
      resExp  <= nExp;
      ovfFlag <= nOvf;
      unfFlag <= nUnf;
    end
  end

  // R2: nonzero results carry a normalized mantissa
  p_norm_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && resMant != '0) |-> (resMant[MW-1] != resMant[MW-2]));
  // R3: overflow saturates at the top exponent
  p_sat_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ovfFlag) |-> (resExp == EW'(EMAX) &&
      (resMant == {1'b0, {(MW-1){1'b1}}} || resMant == {1'b1, {(MW-1){1'b0}}})));
  // R4: underflow returns the zero encoding
  p_flush_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && unfFlag) |-> (resMant == '0 && resExp == EW'(EMIN) && !ovfFlag));
  // R5: every zero mantissa carries the minimum exponent
  p_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && resMant == '0) |-> (resExp == EW'(EMIN) && !ovfFlag));

endmodule

// File: rtl/tcf_addsub.sv
module tcf_addsub
  import tcf_pkg::*;
#(
  parameter int MW = 24,
  parameter int GW = 8,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          subOp,
  input  logic [MW-1:0] aMant,
  input  logic [EW-1:0] aExp,
  input  logic [MW-1:0] bMant,
  input  logic [EW-1:0] bExp,
  output logic          outValid,
  output logic [MW-1:0] resMant,
  output logic [EW-1:0] resExp,
  output logic          ovfFlag,
  output logic          unfFlag
);

  tcfStrobe_t strobes;

  tcf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  tcf_dpath #(.MW(MW), .GW(GW), .EW(EW)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .outValid(outValid),
    .subOp   (subOp),
    .aMant   (aMant),
    .aExp    (aExp),
    .bMant   (bMant),
    .bExp    (bExp),
    .resMant (resMant),
    .resExp  (resExp),
    .ovfFlag (ovfFlag),
    .unfFlag (unfFlag)
  );

endmodule

// File: tb/tb_tcf_addsub.sv
`timescale 1ns/1ps
module tb_tcf_addsub;

  logic        clk = 1'b0;
  logic        rstN, inValid, subOp;
  logic [23:0] aMant, bMant;
  logic [7:0]  aExp, bExp;
  logic        outValid, ovfFlag, unfFlag;
  logic [23:0] resMant;
  logic [7:0]  resExp;

  always #4 clk = ~clk;  // 125 MHz

  tcf_addsub dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .subOp(subOp),
    .aMant(aMant), .aExp(aExp), .bMant(bMant), .bExp(bExp),
    .outValid(outValid), .resMant(resMant), .resExp(resExp),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  typedef struct packed {
    logic [23:0] m;
    logic [7:0]  e;
    logic        o;
    logic        u;
  } res_t;

  res_t  expQ[$];
  string tagQ[$];
  int    cycQ[$];
  int    cyc = 0, checks = 0, errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model: exact wide-integer arithmetic following the requirements.
  function automatic res_t model(input logic [23:0] ma, input logic [7:0] ea,
                                 input logic [23:0] mb, input logic [7:0] eb,
                                 input logic sub);
    res_t   r;
    longint xa, xb, big, sm, s;
    int     iea, ieb, be, d, n, k, ex;
    xa  = longint'($signed(ma)) * 256;
    xb  = longint'($signed(mb)) * 256;
    if (sub) xb = -xb;
    iea = int'($signed(ea));
    ieb = int'($signed(eb));
    if (iea >= ieb) begin big = xa; sm = xb; be = iea; d = iea - ieb; end
    else            begin big = xb; sm = xa; be = ieb; d = ieb - iea; end
    if (d > 62) d = 62;
    sm = sm >>> d;
    s  = big + sm;
    r  = '0;
    if (s == 0) begin
      r.e = 8'h80;
      return r;
    end
    n = 1;
    while (!(s >= -(64'sd1 <<< (n - 1)) && s < (64'sd1 <<< (n - 1)))) n++;
    k  = n - 24;
    ex = be - 8 + k;
    if (ex > 127) begin
      r.o = 1'b1; r.e = 8'h7F;
      r.m = (s < 0) ? 24'h800000 : 24'h7FFFFF;
    end else if (ex < -128) begin
      r.u = 1'b1; r.e = 8'h80; r.m = '0;
    end else begin
      r.m = (k >= 0) ? 24'(s >>> k) : 24'(s <<< (-k));
      r.e = 8'(ex);
    end
    return r;
  endfunction

  // Monitor: pops the scoreboard as results appear
  res_t  gotE;
  string gotT;
  int    gotC;
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected outValid, got 1 expected 0");
      end else begin
        gotE = expQ.pop_front();
        gotT = tagQ.pop_front();
        gotC = cycQ.pop_front();
        if ({resMant, resExp, ovfFlag, unfFlag} !== gotE) begin
          errors++;
          $display("FAIL %s: got m=%h e=%h o=%b u=%b expected m=%h e=%h o=%b u=%b",
                   gotT, resMant, resExp, ovfFlag, unfFlag, gotE.m, gotE.e, gotE.o, gotE.u);
        end
        checks++;
        if (cyc - gotC != 3) begin
          errors++;
          $display("FAIL R1 latency (%s): got %0d expected 3", gotT, cyc - gotC);
        end
      end
    end
  end

  task automatic issue(input logic [23:0] ma, input logic [7:0] ea,
                       input logic [23:0] mb, input logic [7:0] eb,
                       input logic sub, input string tag);
    @(negedge clk);
    aMant = ma; aExp = ea; bMant = mb; bExp = eb; subOp = sub; inValid = 1'b1;
    expQ.push_back(model(ma, ea, mb, eb, sub));
    tagQ.push_back(tag);
    cycQ.push_back(cyc);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Watchdog
  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  logic [23:0] rm;
  initial begin
    rstN = 1'b0; inValid = 1'b0; subOp = 1'b0;
    aMant = '0; bMant = '0; aExp = '0; bExp = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got outValid=%b expected 0", outValid);
    end
    rstN = 1'b1;

    // back-to-back directed operations
    issue(24'h400000, 8'd0,    24'h400000, 8'd0,    1'b0, "R10 equal exponents add");
    issue(24'h600000, 8'd3,    24'h400000, 8'd4,    1'b1, "R6 close subtract exact");
    issue(24'h400000, 8'd4,    24'h600000, 8'd3,    1'b1, "R6 close subtract reversed");
    issue(24'h500000, 8'd2,    24'hA00000, 8'd10,   1'b0, "R6 shift of eight exact");
    issue(24'h400000, 8'd0,    24'hC00000, 8'(-100), 1'b0, "R7 far negative sign fill");
    issue(24'h400000, 8'd0,    24'h400000, 8'(-40), 1'b0, "R7 far positive vanishes");
    issue(24'h400000, 8'(-40), 24'h400000, 8'd0,    1'b0, "R10 swapped far operands");
    issue(24'h000000, 8'h80,   24'h800000, 8'd5,    1'b1, "R8 negate most negative");
    issue(24'h000000, 8'h80,   24'h800000, 8'd127,  1'b1, "R3 negation overflow");
    issue(24'h7FFFFF, 8'd127,  24'h7FFFFF, 8'd127,  1'b0, "R3 positive overflow");
    issue(24'h800000, 8'd127,  24'h800000, 8'd127,  1'b0, "R3 negative overflow");
    issue(24'h000000, 8'h80,   24'h400000, 8'h80,   1'b1, "R4 negation underflow");
    issue(24'h400001, 8'h80,   24'h400000, 8'h80,   1'b1, "R4 tiny difference flushed");
    issue(24'h5A5A5A, 8'd9,    24'h5A5A5A, 8'd9,    1'b1, "R5 exact cancellation");
    issue(24'h400001, 8'd0,    24'h400000, 8'd0,    1'b0, "R9 positive truncation");
    issue(24'hBFFFFF, 8'd0,    24'hC00000, 8'd0,    1'b0, "R9 negative truncation floor");
    issue(24'h7FFFFF, 8'(-5),  24'h800000, 8'(-6),  1'b1, "R8 subtract negative mantissa");
    idle(6);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: got outValid=%b expected 0", outValid);
    end

    // normalized random operands, gapped and streamed
    for (int i = 0; i < 60; i++) begin
      rm = 24'($urandom);
      rm[22] = ~rm[23];
      issue(rm, 8'($signed($urandom_range(40)) - 20),
            {~rm[15], rm[15], rm[21:0]} ^ 24'h155555,
            8'($signed($urandom_range(40)) - 20), 1'($urandom), "R2 random normalized");
      if (i % 7 == 0) idle(2);
    end
    idle(1);

    for (int i = 0; i < 200 && expQ.size() > 0; i++) @(negedge clk);
    if (expQ.size() > 0) begin
      checks++;
      errors++;
      $display("FAIL R1 drain: got %0d pending expected 0", expQ.size());
    end
    summary();
  end

endmodule